// File: doc/BRIEF.md
# Bus Master Command Sequencer

This block sits in the system clock domain behind a serial debug port. Every cycle it sees the port's current instruction code and data word, already synchronized. Instruction codes that load an operand copy the data word into the address register, the single-write data register, the burst length register, the buffer index register, or one entry of a small burst data buffer. The access codes start a bus operation on an AXI4 master port: a single write, a single read, a burst write or a burst read.

An access begins only on the cycle its code first appears. Bursts run as a series of single transfers to consecutive word addresses. A burst write takes its data from the buffer entry whose number matches the beat. Every wait on a bus channel is bounded by a timeout counter, so the engine always returns to idle. Read results are handed back one word at a time through a valid/taken handshake, and the engine holds each word until the serial side takes it.

Top module: `axiCmdSequencer`

## Requirements
- R1: After reset, and whenever no access is in progress, awValid, wValid, bReady, arValid, rReady and fwdValid are all low. At most one of the phases (address/data, response, read address, read data, forward) is active in any cycle.
- R2: On each clock edge where instrIn holds a load code, dataIn is stored as follows. 0x02 loads the address. 0x03 loads the single-write data. 0x08 loads the burst length. 0x0A loads the buffer index. 0x0B writes the buffer entry selected by the current index.
- R3: A change of instrIn to 0x01 (write) raises awValid and wValid together in the next cycle, with the loaded address and data. Each valid drops on its own handshake, so AW and W may complete in different cycles.
- R4: After both AW and W have completed, bReady rises exactly two cycles after the later of the two handshakes. It stays high until bValid is seen.
- R5: A change of instrIn to 0x04 (read) drives arValid with the loaded address until arReady is seen. rReady rises exactly two cycles after that handshake. RDATA is captured on the rValid handshake, and fwdValid then holds fwdData steady until fwdTaken is high at a clock edge.
- R6: Each of the four bus wait phases (AW/W, B, AR, R) ends after 256 cycles if no handshake arrives. A read that times out in the R phase forwards the value zero.
- R7: A change of instrIn to 0x09 (burst write) performs as many single writes as the burst length (a length of 0 performs one). Beat i uses address + 4·i and data from buffer entry i.
- R8: A change of instrIn to 0x0C (burst read) performs as many single reads as the burst length, at address + 4·i. Each word is forwarded and taken before the next read address is issued.
- R9: An access code held on instrIn starts only one operation. An access code that first appears while an operation is in progress is dropped and does not start later.
- R10: While awValid or arValid waits for its ready, the address on the bus does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrIn | input | 8 | Current instruction code from the serial port |
| dataIn | input | DW | Current data word from the serial port |
| fwdValid | output | 1 | Read word available for the serial side |
| fwdData | output | DW | Read word being forwarded |
| fwdTaken | input | 1 | Serial side has taken the forwarded word |
| awAddr | output | AW | Write address |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| wData | output | DW | Write data |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |
| arAddr | output | AW | Read address |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rData | input | DW | Read data |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |

## Verification
Each result has a fixed due cycle. The valids of a new access appear one cycle after its code changes. bReady and rReady rise two cycles after the last address-phase handshake. A timed-out phase holds its valid or ready for 256 cycles. A forwarded word stays up until the cycle after fwdTaken. The bench drives on the falling edge and samples there. Its slave model drives the handshake inputs, waits 1 ns, and then logs which handshakes will occur at the coming rising edge. Phase gaps and timeout lengths are measured as falling-edge counts against these fixed values. Written addresses and data are compared with bench-computed expectations after the engine has been quiet for three cycles.

// File: rtl/axiSeqPkg.sv
package axiSeqPkg;

  // instruction codes seen on the serial side
  localparam logic [7:0] OP_WRITE  = 8'h01;
  localparam logic [7:0] OP_ADDR   = 8'h02;
  localparam logic [7:0] OP_DATA   = 8'h03;
  localparam logic [7:0] OP_READ   = 8'h04;
  localparam logic [7:0] OP_COUNT  = 8'h08;
  localparam logic [7:0] OP_BWRITE = 8'h09;
  localparam logic [7:0] OP_INDEX  = 8'h0A;
  localparam logic [7:0] OP_BDATA  = 8'h0B;
  localparam logic [7:0] OP_BREAD  = 8'h0C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ADDR_DATA,
    ST_WR_CLR,
    ST_WR_RESP,
    ST_RD_ADDR,
    ST_RD_CLR,
    ST_RD_DATA,
    ST_FORWARD
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic beatInit;   // load working address, zero beat index
    logic burst;      // mode captured with beatInit
    logic beatNext;   // advance to next consecutive word
    logic cntClr;     // zero timeout counter
    logic cntRun;     // count one waiting cycle
    logic hsClr;      // forget AW/W handshakes
    logic rdCapture;  // store read word (or zero on timeout)
  } seqStrobe_t;

endpackage

// File: rtl/axiSeqData.sv
module axiSeqData
  import axiSeqPkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int TOW   = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    instrIn,
  input  logic [DW-1:0] dataIn,
  input  seqStrobe_t    strobe,
  input  logic          awFire,
  input  logic          wFire,
  input  logic          rFire,
  input  logic [DW-1:0] rDataIn,
  output logic          cmdWr,
  output logic          cmdRd,
  output logic          cmdBurst,
  output logic          timeout,
  output logic          lastBeat,
  output logic          awDone,
  output logic          wDone,
  output logic [AW-1:0] curAddr,
  output logic [DW-1:0] wDataOut,
  output logic [DW-1:0] rdWord
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [TOW-1:0] TMAX = '1;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [7:0]     prevInstr;
  logic [AW-1:0]  addrReg;
  logic [DW-1:0]  dataReg;
  logic [CW-1:0]  burstLen;
  logic [IW-1:0]  bufIdx;
  logic [CW-1:0]  beatIdx;
  logic           burstMode;
  logic [TOW-1:0] tmoCnt;
  logic [DW-1:0]  bufMem [DEPTH];

  logic isNew;
  assign isNew    = (instrIn != prevInstr);
  assign cmdWr    = isNew && (instrIn == OP_WRITE || instrIn == OP_BWRITE);
  assign cmdRd    = isNew && (instrIn == OP_READ  || instrIn == OP_BREAD);
  assign cmdBurst = (instrIn == OP_BWRITE) || (instrIn == OP_BREAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevInstr <= '0;
      addrReg   <= '0;
      dataReg   <= '0;
      burstLen  <= '0;
      bufIdx    <= '0;
    end else begin
      prevInstr <= instrIn;
      unique case (instrIn)
        OP_ADDR:  addrReg  <= AW'(dataIn);
        OP_DATA:  dataReg  <= dataIn;
        OP_COUNT: burstLen <= dataIn[CW-1:0];
        OP_INDEX: bufIdx   <= dataIn[IW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (instrIn == OP_BDATA) bufMem[bufIdx] <= dataIn;
  end

  // beat sequencing over consecutive words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatIdx   <= '0;
      curAddr   <= '0;
      burstMode <= 1'b0;
    end else if (strobe.beatInit) begin
      beatIdx   <= '0;
      curAddr   <= addrReg;
      burstMode <= strobe.burst;
    end else if (strobe.beatNext) begin
      beatIdx   <= beatIdx + 1'b1;
      curAddr   <= curAddr + STEP;
    end
  end

  logic [CW:0] beatsDone;
  assign beatsDone = {1'b0, beatIdx} + 1'b1;
  assign lastBeat  = !burstMode || (beatsDone >= {1'b0, burstLen});
  assign wDataOut  = burstMode ? bufMem[beatIdx[IW-1:0]] : dataReg;

  // timeout guard and per-channel handshake memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt <= '0;
      awDone <= 1'b0;
      wDone  <= 1'b0;
      rdWord <= '0;
    end else begin
      if (strobe.cntClr)      tmoCnt <= '0;
      else if (strobe.cntRun) tmoCnt <= tmoCnt + 1'b1;
      if (strobe.hsClr) begin
        awDone <= 1'b0;
        wDone  <= 1'b0;
      end else begin
        if (awFire) awDone <= 1'b1;
        if (wFire)  wDone  <= 1'b1;
      end
      if (strobe.rdCapture) rdWord <= rFire ? rDataIn : '0;
    end
  end
  assign timeout = (tmoCnt == TMAX);

  AST_TMO_ZERO_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatInit |=> !timeout && !awDone && !wDone) else $error("start state"); // R6

endmodule

// File: rtl/axiSeqCtrl.sv
module axiSeqCtrl
  import axiSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       cmdRd,
  input  logic       cmdBurst,
  input  logic       timeout,
  input  logic       lastBeat,
  input  logic       awDone,
  input  logic       wDone,
  input  logic       awReady,
  input  logic       wReady,
  input  logic       bValid,
  input  logic       arReady,
  input  logic       rValid,
  input  logic       fwdTaken,
  output seqStrobe_t strobe,
  output logic       awValid,
  output logic       wValid,
  output logic       bReady,
  output logic       arValid,
  output logic       rReady,
  output logic       fwdValid
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign awValid  = (state == ST_WR_ADDR_DATA) && !awDone;
  assign wValid   = (state == ST_WR_ADDR_DATA) && !wDone;
  assign bReady   = (state == ST_WR_RESP);
  assign arValid  = (state == ST_RD_ADDR);
  assign rReady   = (state == ST_RD_DATA);
  assign fwdValid = (state == ST_FORWARD);

  logic awOk, wOk;
  assign awOk = awDone || (awValid && awReady);
  assign wOk  = wDone  || (wValid && wReady);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdWr || cmdRd) begin
          nextState       = cmdWr ? ST_WR_ADDR_DATA : ST_RD_ADDR;
          strobe.beatInit = 1'b1;
          strobe.burst    = cmdBurst;
          strobe.cntClr   = 1'b1;
          strobe.hsClr    = 1'b1;
        end
      end
      ST_WR_ADDR_DATA: begin
        strobe.cntRun = 1'b1;
        if ((awOk && wOk) || timeout) nextState = ST_WR_CLR;
      end
      ST_WR_CLR: begin
        strobe.cntClr = 1'b1;
        strobe.hsClr  = 1'b1;
        nextState     = ST_WR_RESP;
      end
      ST_WR_RESP: begin
        strobe.cntRun = 1'b1;
        if (bValid || timeout) begin
          strobe.cntClr = 1'b1;
          if (lastBeat) nextState = ST_IDLE;
          else begin
            strobe.beatNext = 1'b1;
            nextState       = ST_WR_ADDR_DATA;
          end
        end
      end
      ST_RD_ADDR: begin
        strobe.cntRun = 1'b1;
        if (arReady || timeout) nextState = ST_RD_CLR;
      end
      ST_RD_CLR: begin
        strobe.cntClr = 1'b1;
        nextState     = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        strobe.cntRun = 1'b1;
        if (rValid || timeout) begin
          strobe.rdCapture = 1'b1;
          nextState        = ST_FORWARD;
        end
      end
      ST_FORWARD: begin
        if (fwdTaken) begin
          strobe.cntClr = 1'b1;
          if (lastBeat) nextState = ST_IDLE;
          else begin
            strobe.beatNext = 1'b1;
            nextState       = ST_RD_ADDR;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({awValid || wValid, bReady, arValid, rReady, fwdValid})) else $error("phase overlap"); // R1
  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_CLR) |=> bReady) else $error("write gap"); // R4
  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady) |=> !rReady ##1 rReady) else $error("read gap"); // R5
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdTaken) |=> fwdValid) else $error("forward dropped"); // R5
  AST_TMO_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && timeout) |=> !arValid) else $error("no timeout exit"); // R6

endmodule

// File: rtl/axiCmdSequencer.sv
module axiCmdSequencer
  import axiSeqPkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int TOW   = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    instrIn,
  input  logic [DW-1:0] dataIn,
  output logic          fwdValid,
  output logic [DW-1:0] fwdData,
  input  logic          fwdTaken,
  output logic [AW-1:0] awAddr,
  output logic          awValid,
  input  logic          awReady,
  output logic [DW-1:0] wData,
  output logic          wValid,
  input  logic          wReady,
  input  logic          bValid,
  output logic          bReady,
  output logic [AW-1:0] arAddr,
  output logic          arValid,
  input  logic          arReady,
  input  logic [DW-1:0] rData,
  input  logic          rValid,
  output logic          rReady
);

  seqStrobe_t    strobe;
  logic          cmdWr, cmdRd, cmdBurst, timeout, lastBeat, awDone, wDone;
  logic [AW-1:0] curAddr;

  axiSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdRd(cmdRd), .cmdBurst(cmdBurst),
    .timeout(timeout), .lastBeat(lastBeat), .awDone(awDone), .wDone(wDone),
    .awReady(awReady), .wReady(wReady), .bValid(bValid), .arReady(arReady),
    .rValid(rValid), .fwdTaken(fwdTaken), .strobe(strobe), .awValid(awValid),
    .wValid(wValid), .bReady(bReady), .arValid(arValid), .rReady(rReady),
    .fwdValid(fwdValid)
  );

  axiSeqData #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .TOW(TOW)) uData (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .dataIn(dataIn), .strobe(strobe),
    .awFire(awValid && awReady), .wFire(wValid && wReady), .rFire(rValid && rReady),
    .rDataIn(rData), .cmdWr(cmdWr), .cmdRd(cmdRd), .cmdBurst(cmdBurst),
    .timeout(timeout), .lastBeat(lastBeat), .awDone(awDone), .wDone(wDone),
    .curAddr(curAddr), .wDataOut(wData), .rdWord(fwdData)
  );

  assign awAddr = curAddr;
  assign arAddr = curAddr;

  AST_AWADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady && !timeout) |=> awValid && $stable(awAddr)) else $error("aw moved"); // R10
  AST_ARADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady && !timeout) |=> arValid && $stable(arAddr)) else $error("ar moved"); // R10

endmodule

// File: tb/axiCmdSequencer_test.sv
`timescale 1ns/1ps
module axiCmdSequencer_test;
  import axiSeqPkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [7:0]  instrIn;
  logic [31:0] dataIn, fwdData, awAddr, wData, arAddr, rData;
  logic fwdValid, fwdTaken, awValid, awReady, wValid, wReady, bValid, bReady;
  logic arValid, arReady, rValid, rReady;

  axiCmdSequencer uut (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .dataIn(dataIn), .fwdValid(fwdValid),
    .fwdData(fwdData), .fwdTaken(fwdTaken), .awAddr(awAddr), .awValid(awValid),
    .awReady(awReady), .wData(wData), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady), .arAddr(arAddr), .arValid(arValid),
    .arReady(arReady), .rData(rData), .rValid(rValid), .rReady(rReady)
  );

  int tests = 0, fails = 0;
  int rdyPct = 100;
  bit blockAll = 1'b0;
  int cyc = 0;

  logic [31:0] awLog [0:1023];
  logic [31:0] wLog  [0:1023];
  logic [31:0] arLog [0:1023];
  int awN = 0, wN = 0, bN = 0, arN = 0;
  logic [31:0] bufShadow [0:15];

  function automatic logic [31:0] rdFunc(input logic [31:0] a);
    return a ^ 32'hA5C3_0F01;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // slave model: drive handshake inputs, then log what fires at the next rising edge
  logic [31:0] rAddr = '0;
  bit rPend = 1'b0, prevB = 1'b0, prevR = 1'b0, prevAw = 1'b0, prevAwFire = 1'b0;
  logic [31:0] prevAwAddr = '0;
  int lastAddrCyc = 0, lastArCyc = 0, stabFails = 0;

  always @(negedge clk) begin
    int bPend;
    cyc++;
    bPend   = ((awN < wN) ? awN : wN) - bN;
    awReady = !blockAll && (($urandom % 100) < rdyPct);
    wReady  = !blockAll && (($urandom % 100) < rdyPct);
    arReady = !blockAll && (($urandom % 100) < rdyPct);
    bValid  = !blockAll && (bPend > 0) && (($urandom % 100) < rdyPct);
    rValid  = !blockAll && rPend && (($urandom % 100) < rdyPct);
    rData   = rPend ? rdFunc(rAddr) : 32'h0;
    #1;
    if (awValid && prevAw && !prevAwFire && awAddr != prevAwAddr) stabFails++;
    prevAw = awValid; prevAwAddr = awAddr; prevAwFire = awValid && awReady;
    if (awValid && awReady) begin awLog[awN] = awAddr; awN++; lastAddrCyc = cyc; end
    if (wValid && wReady)   begin wLog[wN] = wData; wN++; lastAddrCyc = cyc; end
    if (bValid && bReady) bN++;
    if (arValid && arReady) begin arLog[arN] = arAddr; arN++; rPend = 1'b1; rAddr = arAddr; lastArCyc = cyc; end
    if (rValid && rReady) rPend = 1'b0;
    if (bReady && !prevB && !blockAll)
      check(cyc - lastAddrCyc == 2, "R4 bReady gap", 32'(cyc - lastAddrCyc), 32'd2);
    if (rReady && !prevR && !blockAll)
      check(cyc - lastArCyc == 2, "R5 rReady gap", 32'(cyc - lastArCyc), 32'd2);
    prevB = bReady; prevR = rReady;
  end

  task automatic load(input logic [7:0] code, input logic [31:0] d);
    @(negedge clk);
    instrIn = code; dataIn = d;
    if (code == OP_BDATA) bufShadow[idxShadow] = d;
    if (code == OP_INDEX) idxShadow = d[3:0];
  endtask
  logic [3:0] idxShadow = '0;

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!(awValid || wValid || bReady || arValid || rReady || fwdValid)) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic doWrite(input logic [31:0] addr, input bit burst, input int n, input logic [31:0] dat [0:15]);
    int beats, aw0, w0, b0;
    load(OP_ADDR, addr);
    if (burst) begin
      load(OP_COUNT, 32'(n));
      for (int i = 0; i < n; i++) begin
        load(OP_INDEX, 32'(i));
        load(OP_BDATA, dat[i]);
      end
    end else load(OP_DATA, dat[0]);
    beats = burst ? ((n == 0) ? 1 : n) : 1;
    aw0 = awN; w0 = wN; b0 = bN;
    @(negedge clk) instrIn = burst ? OP_BWRITE : OP_WRITE;
    @(negedge clk);
    check(awValid && wValid, "R3 valids one cycle after code", {30'd0, awValid, wValid}, 32'd3);
    waitIdle();
    check(awN == aw0 + beats, burst ? "R7 aw count" : "R3 aw count", 32'(awN - aw0), 32'(beats));
    check(bN == b0 + beats, "R4 responses", 32'(bN - b0), 32'(beats));
    for (int i = 0; i < beats; i++) begin
      check(awLog[aw0+i] == addr + 32'(4*i), burst ? "R7 address" : "R3 address", awLog[aw0+i], addr + 32'(4*i));
      check(wLog[w0+i] == (burst ? bufShadow[i] : dat[0]), burst ? "R7 data" : "R2 data",
            wLog[w0+i], burst ? bufShadow[i] : dat[0]);
    end
  endtask

  task automatic takeFwd(input logic [31:0] exp, input string tag);
    int guard = 0, d;
    @(negedge clk);
    while (!fwdValid && guard < 2000) begin @(negedge clk); guard++; end
    check(fwdValid && fwdData == exp, tag, fwdData, exp);
    d = $urandom % 3;
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      check(fwdValid && fwdData == exp, "R5 forward held", fwdData, exp);
    end
    fwdTaken = 1'b1;
    @(negedge clk) fwdTaken = 1'b0;
  endtask

  task automatic doRead(input logic [31:0] addr, input bit burst, input int n);
    int beats, ar0;
    load(OP_ADDR, addr);
    if (burst) load(OP_COUNT, 32'(n));
    beats = burst ? ((n == 0) ? 1 : n) : 1;
    ar0 = arN;
    @(negedge clk) instrIn = burst ? OP_BREAD : OP_READ;
    for (int i = 0; i < beats; i++)
      takeFwd(rdFunc(addr + 32'(4*i)), burst ? "R8 burst word" : "R5 read word");
    waitIdle();
    check(arN == ar0 + beats, burst ? "R8 ar count" : "R5 ar count", 32'(arN - ar0), 32'(beats));
    for (int i = 0; i < beats; i++)
      check(arLog[ar0+i] == addr + 32'(4*i), burst ? "R8 address" : "R5 address", arLog[ar0+i], addr + 32'(4*i));
  endtask

  task automatic countHigh(input int sel, output int c);
    c = 0;
    while (!(sel == 0 ? awValid : sel == 1 ? bReady : sel == 2 ? arValid : rReady)) @(negedge clk);
    while (sel == 0 ? awValid : sel == 1 ? bReady : sel == 2 ? arValid : rReady) begin c++; @(negedge clk); end
  endtask

  initial begin
    logic [31:0] dat [0:15];
    int c, aw0;
    void'($urandom(32'h1F2E3D4C));
    rstN = 1'b0; instrIn = 8'h00; dataIn = '0; fwdTaken = 1'b0;
    for (int i = 0; i < 16; i++) begin dat[i] = 32'h0; bufShadow[i] = 32'h0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!(awValid || wValid || bReady || arValid || rReady || fwdValid), "R1 reset outputs",
          {26'd0, awValid, wValid, bReady, arValid, rReady, fwdValid}, 32'd0);

    dat[0] = 32'hDEAD_BEEF;
    doWrite(32'h0000_1000, 1'b0, 1, dat);
    rdyPct = 40; dat[0] = 32'h1234_5678;
    doWrite(32'h0000_2040, 1'b0, 1, dat);
    doRead(32'h0000_3000, 1'b0, 1);

    // R9: held read code does not restart
    aw0 = arN;
    repeat (20) @(negedge clk);
    check(arN == aw0 && !arValid, "R9 held code no restart", 32'(arN - aw0), 32'd0);

    for (int i = 0; i < 16; i++) dat[i] = $urandom;
    doWrite(32'h0000_4000, 1'b1, 5, dat);
    doWrite(32'h0000_5000, 1'b1, 0, dat);   // R7 length zero is one beat
    doRead(32'h0000_6000, 1'b1, 3);

    // R6 write timeouts
    blockAll = 1'b1; aw0 = awN;
    load(OP_ADDR, 32'h7000); load(OP_DATA, 32'h55);
    @(negedge clk) instrIn = OP_WRITE;
    countHigh(0, c);
    check(c == 256, "R6 AW/W timeout length", 32'(c), 32'd256);
    countHigh(1, c);
    check(c == 256, "R6 B timeout length", 32'(c), 32'd256);
    waitIdle();
    check(awN == aw0, "R6 no write fired", 32'(awN - aw0), 32'd0);

    // R6 read timeouts forward zero
    load(OP_ADDR, 32'h8000);
    @(negedge clk) instrIn = OP_READ;
    countHigh(2, c);
    check(c == 256, "R6 AR timeout length", 32'(c), 32'd256);
    countHigh(3, c);
    check(c == 256, "R6 R timeout length", 32'(c), 32'd256);
    takeFwd(32'h0, "R6 timeout forwards zero");
    waitIdle();

    // R9: access code arriving mid-operation is dropped
    load(OP_ADDR, 32'h9000);
    @(negedge clk) instrIn = OP_READ;
    repeat (10) @(negedge clk);
    instrIn = OP_WRITE;
    takeFwd(32'h0, "R6 timeout forwards zero");
    waitIdle();
    blockAll = 1'b0; aw0 = awN;
    repeat (20) @(negedge clk);
    check(awN == aw0 && !awValid, "R9 busy code dropped", 32'(awN - aw0), 32'd0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      logic [31:0] a;
      rdyPct = 20 + ($urandom % 81);
      op = $urandom % 4;
      a = {$urandom, 2'b00} & 32'h00FF_FFFC;
      for (int i = 0; i < 16; i++) dat[i] = $urandom;
      case (op)
        0: doWrite(a, 1'b0, 1, dat);
        1: doRead(a, 1'b0, 1);
        2: doWrite(a, 1'b1, 1 + ($urandom % 6), dat);
        default: doRead(a, 1'b1, 1 + ($urandom % 4));
      endcase
    end

    check(stabFails == 0, "R10 address stable while waiting", 32'(stabFails), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule